// File: doc/BRIEF.md
# Load-Use and Branch Stall/Flush Controller

This block decides, every cycle, whether a five-stage in-order pipeline may advance. The branches in that pipeline are resolved in the decode stage. The block takes the 32-bit instruction word held in decode and the equality result of the branch comparator. It then keeps its own record of what sits in the execute and memory stages: the destination register, whether the instruction writes a register, and whether it is a load.

From these inputs it drives the program-counter write enable, the fetch/decode register write enable and a bubble select. The bubble select replaces the control bits entering execute with zeros. It also drives a flush that clears the fetched instruction when a branch is taken.

The stall rule depends on the kind of consumer:

- **ALU, store or other non-branch consumer.** It waits one cycle behind a load.
- **Branch consumer.** It waits one cycle behind an ALU producer and two cycles behind a load producer, because its operands are needed one stage earlier.

A saturating counter reports how many consecutive cycles the pipeline has been held, so that stall lengths can be observed directly. The forwarding multiplexers and the datapath sit outside this block.

Top module: `hazard_flush_ctrl`

## Requirements
- R1: When the instruction in execute is a load (opcode 35) whose destination equals a source register of the decode instruction, a stall is raised that cycle. For a consumer that is not a branch, the stall lasts exactly one cycle. An ALU producer in execute feeding a non-branch consumer causes no stall.
- R2: In a stall cycle `pc_we` and `ifid_we` are 0 and `ctl_bubble` is 1. In every other cycle `pc_we` and `ifid_we` are 1 and `ctl_bubble` is 0.
- R3: A stall cycle places an empty slot into execute, so the held instruction cannot act as a producer on the following cycle. The stalled instruction and everything after it are delayed by one cycle per stall.
- R4: A branch (opcode 4) in decode whose rs or rt equals the destination of a register-writing non-load instruction in execute stalls for one cycle. Such a producer in the memory stage causes no stall.
- R5: A branch whose rs or rt equals the destination of a load directly ahead of it stalls for two consecutive cycles: once while the load is in execute and once while it is in memory. No stall run ever exceeds two cycles.
- R6: Register 0 as a destination never causes a stall.
- R7: The decode rules are as follows. R-type (opcode 0, shamt 0) with funct 32, 34, 36, 37 or 42 reads rs and rt and writes rd. A load reads rs and writes rt. Add-immediate (opcode 8) reads rs and writes rt, and its rt is not a source. A store (opcode 43) reads rs and rt and writes nothing. A branch reads rs and rt. Any other word, including all zeros, reads and writes nothing.
- R8: `ifid_flush` is 1 exactly when a branch is in decode, `id_cmp_eq` is 1 and no stall is raised. `pc_we` is then 1 so that the target is loaded. When a stall and a taken branch coincide the stall wins, and the branch is evaluated again once the stall clears.
- R9: `stall_run` equals the number of consecutive stall cycles that ended at the previous clock edge, saturating at all ones. It is 0 after any cycle without a stall.
- R10: After reset the execute and memory records are empty. With an all-zero decode word, the outputs are `pc_we`=1, `ifid_we`=1, `ctl_bubble`=0, `ifid_flush`=0 and `stall_run`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_instr | input | 32 | Instruction word held in the decode stage |
| id_cmp_eq | input | 1 | Branch comparator reports equal operands |
| pc_we | output | 1 | Program counter may be written |
| ifid_we | output | 1 | Fetch/decode register may be written |
| ctl_bubble | output | 1 | Force all control bits entering execute to zero |
| ifid_flush | output | 1 | Clear the fetched instruction (taken branch) |
| stall_run | output | CNT_W | Consecutive stall cycles up to the last edge |

## Verification
The enables, bubble select and flush are combinational on the decode word and the two stage records. The bench therefore compares them in the same cycle as the decode word it drives, one time unit after that word changes at the falling edge. The stage records advance at the next rising edge, so a producer affects the second decode word after it one cycle later. `stall_run` reflects a stall one edge after it occurs. The bench keeps its own execute and memory copies as raw instruction words. It shifts them only after checking each cycle, and it decides whether fetch holds, flushes or advances from its own expected stall and flush of the previous cycle.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  localparam int RW = 5;
  localparam logic [5:0] OP_RTYPE = 6'd0;
  localparam logic [5:0] OP_LOAD  = 6'd35;
  localparam logic [5:0] OP_STORE = 6'd43;
  localparam logic [5:0] OP_BEQ   = 6'd4;
  localparam logic [5:0] OP_ADDI  = 6'd8;
  localparam logic [5:0] FN_ADD = 6'd32, FN_SUB = 6'd34, FN_AND = 6'd36,
                         FN_OR  = 6'd37, FN_SLT = 6'd42;

  typedef logic [RW-1:0] reg_t;

  typedef struct packed {
    logic use_a;   // rs is read
    logic use_b;   // rt is read
    logic branch;
    logic wr;      // writes dst
    logic load;
    reg_t dst;
  } uop_t;

  localparam uop_t UOP_EMPTY = '0;

  function automatic logic alu_funct(input logic [5:0] fn, input logic [4:0] sh);
    return (sh == 5'd0) && (fn == FN_ADD || fn == FN_SUB || fn == FN_AND ||
                            fn == FN_OR  || fn == FN_SLT);
  endfunction

  function automatic uop_t decode_word(input logic [31:0] w);
    uop_t u;
    u = UOP_EMPTY;
    unique case (w[31:26])
      OP_RTYPE: if (alu_funct(w[5:0], w[10:6])) begin
        u.use_a = 1'b1; u.use_b = 1'b1; u.wr = 1'b1; u.dst = w[15:11];
      end
      OP_LOAD:  begin u.use_a = 1'b1; u.wr = 1'b1; u.load = 1'b1; u.dst = w[20:16]; end
      OP_ADDI:  begin u.use_a = 1'b1; u.wr = 1'b1; u.dst = w[20:16]; end
      OP_STORE: begin u.use_a = 1'b1; u.use_b = 1'b1; end
      OP_BEQ:   begin u.use_a = 1'b1; u.use_b = 1'b1; u.branch = 1'b1; end
      default:  u = UOP_EMPTY;
    endcase
    return u;
  endfunction

  // producer p feeds register r of a consumer that reads it
  function automatic logic reg_hit(input uop_t p, input reg_t r, input logic used);
    return used && p.wr && (p.dst != '0) && (p.dst == r);
  endfunction
endpackage

// File: rtl/hzd_decode.sv
module hzd_decode
  import hzd_pkg::*;
(
  input  logic [31:0] instr,
  output uop_t        uop,
  output reg_t        src_a,
  output reg_t        src_b
);
  always_comb begin
    uop   = decode_word(instr);
    src_a = instr[25:21];
    src_b = instr[20:16];
  end
endmodule

// File: rtl/hzd_track.sv
module hzd_track
  import hzd_pkg::*;
#(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  uop_t          id_uop,
  input  logic          bubble,
  output uop_t          ex_uop,
  output uop_t          mem_uop,
  output logic [CW-1:0] run
);
  localparam logic [CW-1:0] RUN_MAX = {CW{1'b1}};

  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
    return (v == RUN_MAX) ? v : v + CW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_uop  <= UOP_EMPTY;
      mem_uop <= UOP_EMPTY;
      run     <= '0;
    end else begin
      ex_uop  <= bubble ? UOP_EMPTY : id_uop;
      mem_uop <= ex_uop;
      run     <= bubble ? sat_inc(run) : '0;
    end
  end
endmodule

// File: rtl/hzd_detect.sv
module hzd_detect
  import hzd_pkg::*;
(
  input  uop_t id_uop,
  input  reg_t src_a,
  input  reg_t src_b,
  input  uop_t ex_uop,
  input  uop_t mem_uop,
  input  logic cmp_eq,
  output logic ld_use,
  output logic br_on_ex,
  output logic br_on_mem_ld,
  output logic stall,
  output logic flush
);
  logic ex_hit, mem_hit;

  always_comb begin
    ex_hit  = reg_hit(ex_uop,  src_a, id_uop.use_a) | reg_hit(ex_uop,  src_b, id_uop.use_b);
    mem_hit = reg_hit(mem_uop, src_a, id_uop.use_a) | reg_hit(mem_uop, src_b, id_uop.use_b);
    ld_use       = ex_uop.load & ex_hit;
    br_on_ex     = id_uop.branch & ex_hit & ~ex_uop.load;
    br_on_mem_ld = id_uop.branch & mem_uop.load & mem_hit;
    stall        = ld_use | br_on_ex | br_on_mem_ld;
    flush        = id_uop.branch & cmp_eq & ~stall;
  end
endmodule

// File: rtl/hazard_flush_ctrl.sv
module hazard_flush_ctrl
  import hzd_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      id_instr,
  input  logic             id_cmp_eq,
  output logic             pc_we,
  output logic             ifid_we,
  output logic             ctl_bubble,
  output logic             ifid_flush,
  output logic [CNT_W-1:0] stall_run
);
  uop_t id_uop, ex_uop, mem_uop;
  reg_t src_a, src_b;
  logic ld_use, br_on_ex, br_on_mem_ld, stall, flush;
  logic id_is_br, ex_wr;

  hzd_decode u_dec (.instr(id_instr), .uop(id_uop), .src_a(src_a), .src_b(src_b));

  hzd_track #(.CW(CNT_W)) u_trk (
    .clk(clk), .rst_n(rst_n), .id_uop(id_uop), .bubble(stall),
    .ex_uop(ex_uop), .mem_uop(mem_uop), .run(stall_run)
  );

  hzd_detect u_det (
    .id_uop(id_uop), .src_a(src_a), .src_b(src_b), .ex_uop(ex_uop),
    .mem_uop(mem_uop), .cmp_eq(id_cmp_eq), .ld_use(ld_use),
    .br_on_ex(br_on_ex), .br_on_mem_ld(br_on_mem_ld),
    .stall(stall), .flush(flush)
  );

  assign id_is_br   = id_uop.branch;
  assign ex_wr      = ex_uop.wr;
  assign pc_we      = ~stall;
  assign ifid_we    = ~stall;
  assign ctl_bubble = stall;
  assign ifid_flush = flush;
endmodule

// File: rtl/hzd_chk.sv
module hzd_chk #(
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pc_we,
  input logic          ctl_bubble,
  input logic          ifid_flush,
  input logic [CW-1:0] stall_run,
  input logic          id_is_br,
  input logic          ex_wr
);
  localparam logic [CW-1:0] RUN_MAX = {CW{1'b1}};

  AST_BUBBLE_EMPTIES_EX: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_bubble |=> !ex_wr); // R3
  AST_NONBR_ONE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_bubble && !id_is_br) |=> !ctl_bubble); // R1
  AST_RUN_AT_MOST_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_run >= CW'(2)) |-> !ctl_bubble); // R5
  AST_RUN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_bubble && stall_run != RUN_MAX) |=> stall_run == $past(stall_run) + CW'(1)); // R9
  AST_RUN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_bubble |=> stall_run == '0); // R9
  AST_FLUSH_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    ifid_flush |-> (pc_we && !ctl_bubble)); // R8
endmodule

bind hazard_flush_ctrl hzd_chk #(.CW(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pc_we(pc_we), .ctl_bubble(ctl_bubble),
  .ifid_flush(ifid_flush), .stall_run(stall_run), .id_is_br(id_is_br), .ex_wr(ex_wr)
);

// File: tb/sim_hazard_flush_ctrl.sv
module sim_hazard_flush_ctrl;
  localparam int CW = 3;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] id_instr = '0;
  logic id_cmp_eq = 1'b0;
  logic pc_we, ifid_we, ctl_bubble, ifid_flush;
  logic [CW-1:0] stall_run;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  hazard_flush_ctrl #(.CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .id_instr(id_instr), .id_cmp_eq(id_cmp_eq),
    .pc_we(pc_we), .ifid_we(ifid_we), .ctl_bubble(ctl_bubble),
    .ifid_flush(ifid_flush), .stall_run(stall_run)
  );

  // encoders
  function automatic logic [31:0] rt_op(int fn, int rs, int rt, int rd);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
  endfunction
  function automatic logic [31:0] it_op(int op, int rs, int rt);
    return {6'(op), 5'(rs), 5'(rt), 16'd0};
  endfunction

  // bench view of the instruction set, per R7
  function automatic bit b_alu(logic [31:0] w);
    int fn = int'(w[5:0]);
    return w[31:26] == 0 && w[10:6] == 0 &&
           (fn == 32 || fn == 34 || fn == 36 || fn == 37 || fn == 42);
  endfunction
  function automatic int b_dst(logic [31:0] w);
    if (b_alu(w)) return int'(w[15:11]);
    if (w[31:26] == 35 || w[31:26] == 8) return int'(w[20:16]);
    return 0;
  endfunction
  function automatic int b_srca(logic [31:0] w);
    if (b_alu(w) || w[31:26] == 35 || w[31:26] == 43 || w[31:26] == 4 || w[31:26] == 8)
      return int'(w[25:21]);
    return 0;
  endfunction
  function automatic int b_srcb(logic [31:0] w);
    if (b_alu(w) || w[31:26] == 43 || w[31:26] == 4) return int'(w[20:16]);
    return 0;
  endfunction
  function automatic bit b_feeds(logic [31:0] p, logic [31:0] c);
    int d = b_dst(p);
    return d != 0 && (d == b_srca(c) || d == b_srcb(c));
  endfunction
  function automatic bit b_stall(logic [31:0] id, logic [31:0] ex, logic [31:0] mem);
    bit br = (id[31:26] == 4);
    return (ex[31:26] == 35 && b_feeds(ex, id)) || (br && b_feeds(ex, id)) ||
           (br && mem[31:26] == 35 && b_feeds(mem, id));
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  logic [31:0] dir_w [18];
  bit          dir_eq [18];
  logic [31:0] ex_m = '0, mem_m = '0;
  int  exp_run = 0;
  bit  prev_stall = 0, prev_flush = 0;
  int  dir_i = 0;

  task automatic fetch_next();
    if (dir_i < 18) begin
      id_instr = dir_w[dir_i]; id_cmp_eq = dir_eq[dir_i]; dir_i++;
    end else begin
      int k = int'($urandom_range(0, 6));
      int a = int'($urandom_range(0, 3)), b = int'($urandom_range(0, 3));
      int c = int'($urandom_range(0, 3));
      case (k)
        0: id_instr = it_op(35, a, b);
        1: id_instr = it_op(43, a, b);
        2: id_instr = it_op(4, a, b);
        3: id_instr = it_op(8, a, b);
        4: id_instr = rt_op(32 + 2 * int'($urandom_range(0, 1)), a, b, c);
        5: id_instr = rt_op(42, a, b, c);
        default: id_instr = '0;
      endcase
      id_cmp_eq = 1'($urandom_range(0, 1));
    end
  endtask

  task automatic step(string tag);
    bit es, ef;
    @(negedge clk);
    if (!prev_stall) begin
      if (prev_flush) begin id_instr = '0; id_cmp_eq = 1'b0; end
      else fetch_next();
    end
    #1;
    es = b_stall(id_instr, ex_m, mem_m);
    ef = (id_instr[31:26] == 4) && id_cmp_eq && !es;
    chk(ctl_bubble == es, {tag, " bubble R1/R4/R5/R6/R7"}, int'(ctl_bubble), int'(es));
    chk(pc_we == !es && ifid_we == !es, {tag, " enables R2"}, int'({pc_we, ifid_we}), es ? 0 : 3);
    chk(ifid_flush == ef, {tag, " flush R8"}, int'(ifid_flush), int'(ef));
    chk(int'(stall_run) == exp_run, {tag, " run R9"}, int'(stall_run), exp_run);
    mem_m = ex_m;
    ex_m  = es ? 32'd0 : id_instr;  // R3: bubble leaves execute empty
    exp_run = es ? ((exp_run == (1 << CW) - 1) ? exp_run : exp_run + 1) : 0;
    prev_stall = es; prev_flush = ef;
  endtask

  initial begin
    void'($urandom(32'd1234));
    dir_w[0]  = it_op(35, 2, 1);        dir_eq[0]  = 0; // lw r1
    dir_w[1]  = rt_op(32, 1, 4, 3);     dir_eq[1]  = 0; // R1 one stall
    dir_w[2]  = rt_op(34, 5, 6, 2);     dir_eq[2]  = 0; // sub r2
    dir_w[3]  = it_op(4, 2, 7);         dir_eq[3]  = 0; // R4 one stall, not taken
    dir_w[4]  = it_op(35, 0, 3);        dir_eq[4]  = 0; // lw r3
    dir_w[5]  = it_op(4, 3, 0);         dir_eq[5]  = 1; // R5 two stalls then R8 flush
    dir_w[6]  = it_op(35, 1, 0);        dir_eq[6]  = 0; // lw r0
    dir_w[7]  = rt_op(32, 0, 0, 4);     dir_eq[7]  = 0; // R6 no stall
    dir_w[8]  = it_op(35, 2, 1);        dir_eq[8]  = 0; // lw r1
    dir_w[9]  = it_op(8, 5, 1);         dir_eq[9]  = 0; // R7 addi rt not a source
    dir_w[10] = it_op(35, 2, 6);        dir_eq[10] = 0; // lw r6
    dir_w[11] = it_op(43, 2, 6);        dir_eq[11] = 0; // R7 store rt is a source
    dir_w[12] = it_op(35, 2, 5);        dir_eq[12] = 0; // lw r5
    dir_w[13] = rt_op(36, 2, 3, 7);     dir_eq[13] = 0; // unrelated
    dir_w[14] = it_op(4, 5, 1);         dir_eq[14] = 1; // R5 load in memory: one stall, flush
    dir_w[15] = rt_op(37, 2, 3, 1);     dir_eq[15] = 0; // or r1
    dir_w[16] = rt_op(32, 2, 2, 4);     dir_eq[16] = 0; // add r4
    dir_w[17] = it_op(4, 1, 0);         dir_eq[17] = 0; // R4 producer in memory: no stall
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(pc_we && ifid_we && !ctl_bubble && !ifid_flush, "reset outputs R10",
        int'({pc_we, ifid_we, ctl_bubble, ifid_flush}), 12);
    chk(stall_run == '0, "reset run R10", int'(stall_run), 0);
    for (int n = 0; n < 40; n++) step("directed");
    for (int n = 0; n < 3000; n++) step("random");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R10 act=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule